// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer with Pulse Generator

This block is a 16-bit up-counter that can serve as an interval timer, an input-capture timer, or a pulse-width generator. It has four modes. In the first, the counter runs up to a period value and clears, and a square-wave output inverts at each period end. In the second, the counter runs freely and the count is latched when an external pin rises. In the last two, the counter drives a PWM output, either for a single period or for every period. A 3-bit source field chooses the count strobe. Seven of its codes select one-cycle enable strobes from an external divider. The eighth code selects the compare strobe of a neighbouring timer, so two timers can be chained.

Software sets up the block through a byte-wide write port. The port loads a control byte, the two 16-bit data registers as separate low and high bytes, and a flag-clear location. The current count and the B register are brought out as observation outputs.

Top module: `tmr16_top`

## Requirements
- R1: After reset the count, the B register, the toggle output, the PWM output and the interrupt flag are all 0.
- R2: Write addresses are: 0 control (bit0 enable, bits 2:1 mode, bits 5:3 source select), 1 A low byte, 2 A high byte, 3 B low byte, 4 B high byte, 5 flag clear. A control write restarts the count at 0, drives the toggle output low and re-arms one-shot mode.
- R3: The count advances by one on each strobe of the selected source, and only while enable is 1. Select codes 0 to 6 pick `tapStrb[code]` and code 7 picks `nbrMatch`. Strobes of unselected sources have no effect.
- R4: In mode 00 (timer), a count strobe that arrives while the count equals A clears the count to 0 and inverts the toggle output.
- R5: In modes 10 and 11, the PWM output is high while the timer is running and the count is below B, and low otherwise. It is low in every other mode and whenever enable is 0.
- R6: In mode 10 (one-shot), the period-end strobe clears the count and stops counting. The PWM output then stays low until the next control write.
- R7: In mode 11 (repeat), counting restarts after every period end without stopping.
- R8: In mode 01 (capture), A is ignored and the count runs freely, wrapping from 0xFFFF to 0.
- R9: In mode 01 with enable set, a rising edge on `capPin` copies the count into B. The new B value appears after the third rising clock edge that samples the pin high. A pin that stays high does not capture again, and nothing is captured while enable is 0.
- R10: The flag is set by a period end in modes 00, 10 and 11, and by a capture in mode 01. Writing 1 to bit0 at address 5 clears it, writing 0 leaves it set, and a set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data byte |
| tapStrb | input | 7 | One-cycle enable strobes from the divider taps |
| nbrMatch | input | 1 | Compare strobe of the neighbouring timer |
| capPin | input | 1 | Asynchronous capture input |
| toggleOut | output | 1 | Square-wave output of timer mode |
| pwmOut | output | 1 | Pulse-width output of the generator modes |
| irqFlag | output | 1 | Interrupt request flag |
| cntVal | output | 16 | Current count |
| bVal | output | 16 | Current B register |

## Verification
A count strobe or a register write held across one clock edge shows up on the count, the toggle, the flag and the B register at the very next edge. The PWM output follows the count with no further delay. A capture edge takes three edges: two synchroniser stages and then the load. The bench drives every input just after a falling edge and samples one falling edge after the edge that should move the result. For captures it also samples one edge early, which shows that B has not yet moved, before it checks the updated value.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_TAPS = 7;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ALO  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_AHI  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_BLO  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_BHI  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd5;

  typedef enum logic [1:0] {
    MODE_TMR = 2'b00,
    MODE_CAP = 2'b01,
    MODE_ONE = 2'b10,
    MODE_REP = 2'b11
  } tmrMode_e;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic capLoad;
  } dpStrb_t;
endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int NUM_SRC_TAPS = NUM_TAPS,
  parameter int SYNC_STAGES  = 2,
  parameter int AW           = ADDR_W,
  localparam int SRC_N  = NUM_SRC_TAPS + 1,
  localparam int SEL_W  = $clog2(SRC_N),
  localparam int CTRL_W = 3 + SEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrEn,
  input  logic [AW-1:0]           wrAddr,
  input  logic [CTRL_W-1:0]       wrData,
  input  logic [NUM_SRC_TAPS-1:0] tapStrb,
  input  logic                    nbrMatch,
  input  logic                    capPin,
  input  logic                    cntEqA,
  input  logic                    cntLtB,
  output dpStrb_t                 strb,
  output logic                    tmrEn,
  output logic                    toggleOut,
  output logic                    pwmOut,
  output logic                    irqFlag
);
  tmrMode_e          mode;
  logic [SEL_W-1:0]  clkSel;
  logic [SRC_N-1:0]  srcVec;
  logic [SYNC_STAGES-1:0] capSync;
  logic capPrev, capRise;
  logic oneDone, running, tick, matchEv, capMode, ppgMode;
  logic ctrlWr, flagClr;

  assign ctrlWr  = wrEn && (wrAddr == ADR_CTRL);
  assign flagClr = wrEn && (wrAddr == ADR_FLAG) && wrData[0];

  // control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrEn  <= 1'b0;
      mode   <= MODE_TMR;
      clkSel <= '0;
    end else if (ctrlWr) begin
      tmrEn  <= wrData[0];
      mode   <= tmrMode_e'(wrData[2:1]);
      clkSel <= wrData[3 +: SEL_W];
    end
  end

  // capture pin synchroniser and edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capSync <= '0;
      capPrev <= 1'b0;
    end else begin
      capSync <= {capSync[SYNC_STAGES-2:0], capPin};
      capPrev <= capSync[SYNC_STAGES-1];
    end
  end
  assign capRise = capSync[SYNC_STAGES-1] && !capPrev;

  assign srcVec  = {nbrMatch, tapStrb};
  assign capMode = (mode == MODE_CAP);
  assign ppgMode = (mode == MODE_ONE) || (mode == MODE_REP);
  assign running = tmrEn && !((mode == MODE_ONE) && oneDone);
  assign tick    = running && srcVec[clkSel];
  assign matchEv = tick && !capMode && cntEqA;

  always_comb begin
    strb.cntClr  = matchEv || ctrlWr;
    strb.cntInc  = tick && !matchEv;
    strb.capLoad = tmrEn && capMode && capRise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oneDone   <= 1'b0;
      toggleOut <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (ctrlWr)                              oneDone <= 1'b0;
      else if (matchEv && mode == MODE_ONE)    oneDone <= 1'b1;

      if (ctrlWr)                              toggleOut <= 1'b0;
      else if (matchEv && mode == MODE_TMR)    toggleOut <= !toggleOut;

      if (matchEv || strb.capLoad)             irqFlag <= 1'b1;
      else if (flagClr)                        irqFlag <= 1'b0;
    end
  end

  assign pwmOut = running && ppgMode && cntLtB;
endmodule

// File: rtl/tmr16_dpath.sv
module tmr16_dpath
  import tmr16_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W,
  localparam int HI_W  = CW - BW,
  localparam int NREGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [BW-1:0] wrData,
  input  dpStrb_t       strb,
  output logic [CW-1:0] cntVal,
  output logic [CW-1:0] bVal,
  output logic          cntEqA,
  output logic          cntLtB
);
  logic [CW-1:0] dataReg [NREGS];
  logic [CW-1:0] cnt;

  // A (index 0) and B (index 1) share one byte-write structure
  for (genvar r = 0; r < NREGS; r++) begin : g_dreg
    localparam logic [AW-1:0] LO_ADR = AW'(ADR_ALO + 2 * r);
    localparam logic [AW-1:0] HI_ADR = AW'(ADR_ALO + 2 * r + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dataReg[r] <= '0;
      end else if (r == 1 && strb.capLoad) begin
        dataReg[r] <= cnt;
      end else if (wrEn && wrAddr == LO_ADR) begin
        dataReg[r][BW-1:0] <= wrData;
      end else if (wrEn && wrAddr == HI_ADR) begin
        dataReg[r][CW-1:BW] <= wrData[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntInc) cnt <= cnt + 1'b1;
  end

  assign cntEqA = (cnt == dataReg[0]);
  assign cntLtB = (cnt <  dataReg[1]);
  assign cntVal = cnt;
  assign bVal   = dataReg[1];
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int TAPS = NUM_TAPS,
  parameter int SYNC = 2,
  localparam int SEL_W  = $clog2(TAPS + 1),
  localparam int CTRL_W = 3 + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [TAPS-1:0]   tapStrb,
  input  logic              nbrMatch,
  input  logic              capPin,
  output logic              toggleOut,
  output logic              pwmOut,
  output logic              irqFlag,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  bVal
);
  dpStrb_t strb;
  logic    cntEqA, cntLtB, tmrEn;

  tmr16_ctrl #(.NUM_SRC_TAPS(TAPS), .SYNC_STAGES(SYNC), .AW(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData[CTRL_W-1:0]), .tapStrb(tapStrb), .nbrMatch(nbrMatch),
    .capPin(capPin), .cntEqA(cntEqA), .cntLtB(cntLtB), .strb(strb),
    .tmrEn(tmrEn), .toggleOut(toggleOut), .pwmOut(pwmOut), .irqFlag(irqFlag)
  );

  tmr16_dpath #(.CW(CNT_W), .BW(BYTE_W), .AW(ADDR_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .cntVal(cntVal), .bVal(bVal), .cntEqA(cntEqA), .cntLtB(cntLtB)
  );
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
  import tmr16_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  bVal,
  input logic              toggleOut,
  input logic              pwmOut,
  input logic              irqFlag,
  input logic              tmrEn
);
  logic ctrlWr, bWr;
  assign ctrlWr = wrEn && (wrAddr == ADR_CTRL);
  assign bWr    = wrEn && (wrAddr == ADR_BLO || wrAddr == ADR_BHI);

  assert_ctrl_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr |=> (cntVal == '0 && !toggleOut));

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmrEn && !ctrlWr) |=> $stable(cntVal));

  assert_toggle_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(toggleOut) && !$past(ctrlWr)) |-> (cntVal == '0 && irqFlag));

  assert_pwm_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwmOut |-> tmrEn);

  assert_capture_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bVal) && !$past(bWr)) |-> irqFlag);
endmodule

bind tmr16_top tmr16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
  .cntVal(cntVal), .bVal(bVal), .toggleOut(toggleOut), .pwmOut(pwmOut),
  .irqFlag(irqFlag), .tmrEn(u_ctrl.tmrEn)
);

// File: tb/tmr16_top_bench.sv
`timescale 1ns/1ps
module tmr16_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [6:0]  tapStrb = '0;
  logic        nbrMatch = 1'b0;
  logic        capPin = 1'b0;
  logic        toggleOut, pwmOut, irqFlag;
  logic [15:0] cntVal, bVal;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr16_top u_tmr16_top (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tapStrb(tapStrb), .nbrMatch(nbrMatch), .capPin(capPin),
    .toggleOut(toggleOut), .pwmOut(pwmOut), .irqFlag(irqFlag),
    .cntVal(cntVal), .bVal(bVal)
  );

  // {en, mode[2], sel[3], A[8], B[8], ticks[8], expCnt[8], expTog, expPwm, expFlag}
  localparam int NV = 13;
  localparam logic [40:0] VECS [NV] = '{
    {1'b1, 2'd0, 3'd0, 8'd3, 8'd0, 8'd2, 8'd2, 1'b0, 1'b0, 1'b0}, // R4 before wrap
    {1'b1, 2'd0, 3'd0, 8'd3, 8'd0, 8'd4, 8'd0, 1'b1, 1'b0, 1'b1}, // R4 first wrap
    {1'b1, 2'd0, 3'd7, 8'd3, 8'd0, 8'd9, 8'd1, 1'b0, 1'b0, 1'b1}, // R3 neighbour source
    {1'b1, 2'd0, 3'd3, 8'd5, 8'd0, 8'd6, 8'd0, 1'b1, 1'b0, 1'b1}, // R4 other period
    {1'b0, 2'd0, 3'd0, 8'd3, 8'd0, 8'd3, 8'd0, 1'b0, 1'b0, 1'b0}, // R3 disabled
    {1'b1, 2'd3, 3'd1, 8'd5, 8'd2, 8'd1, 8'd1, 1'b0, 1'b1, 1'b0}, // R5 high phase
    {1'b1, 2'd3, 3'd1, 8'd5, 8'd2, 8'd3, 8'd3, 1'b0, 1'b0, 1'b0}, // R5 low phase
    {1'b1, 2'd3, 3'd1, 8'd5, 8'd2, 8'd7, 8'd1, 1'b0, 1'b1, 1'b1}, // R7 second period
    {1'b1, 2'd2, 3'd2, 8'd5, 8'd2, 8'd4, 8'd4, 1'b0, 1'b0, 1'b0}, // R5 one-shot low
    {1'b1, 2'd2, 3'd2, 8'd5, 8'd2, 8'd6, 8'd0, 1'b0, 1'b0, 1'b1}, // R6 end of shot
    {1'b1, 2'd2, 3'd2, 8'd5, 8'd2, 8'd9, 8'd0, 1'b0, 1'b0, 1'b1}, // R6 stays stopped
    {1'b1, 2'd2, 3'd2, 8'd5, 8'd2, 8'd0, 8'd0, 1'b0, 1'b1, 1'b0}, // R6 re-armed
    {1'b1, 2'd1, 3'd6, 8'd0, 8'd0, 8'd5, 8'd5, 1'b0, 1'b0, 1'b0}  // R8 A ignored
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse(input int sel);
    if (sel == 7) nbrMatch = 1'b1; else tapStrb[sel] = 1'b1;
    @(negedge clk);
    nbrMatch = 1'b0; tapStrb = '0;
    @(negedge clk);
  endtask

  task automatic waitN(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitN(3);
    // R1 reset state
    check("R1 count", cntVal, 0);
    check("R1 bReg", bVal, 0);
    check("R1 toggle", toggleOut, 0);
    check("R1 pwm", pwmOut, 0);
    check("R1 flag", irqFlag, 0);
    rst_n = 1'b1;
    waitN(1);

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VECS[i];
      wr(3'd1, v[34:27]); wr(3'd2, 8'h00);
      wr(3'd3, v[26:19]); wr(3'd4, 8'h00);
      wr(3'd5, 8'h01);
      wr(3'd0, {2'b00, v[37:35], v[39:38], v[40]});
      for (int k = 0; k < int'(v[18:11]); k++) pulse(int'(v[37:35]));
      check($sformatf("R3 count row %0d", i), cntVal, {24'd0, v[10:3]});
      check($sformatf("R4 toggle row %0d", i), toggleOut, v[2]);
      check($sformatf("R5 pwm row %0d", i), pwmOut, v[1]);
      check($sformatf("R10 flag row %0d", i), irqFlag, v[0]);
    end

    // R3 unselected sources ignored
    wr(3'd1, 8'd100); wr(3'd0, {2'b00, 3'd2, 2'd0, 1'b1});
    pulse(0); pulse(1); pulse(3); pulse(4); pulse(5); pulse(6); pulse(7);
    check("R3 unselected ignored", cntVal, 0);
    pulse(2);
    check("R3 selected counts", cntVal, 1);

    // R2 byte writes of B
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    check("R2 B bytes", bVal, 16'h1234);

    // R10 flag clear: writing 0 keeps it, writing 1 clears
    wr(3'd1, 8'd0); wr(3'd2, 8'd0); wr(3'd0, {2'b00, 3'd0, 2'd0, 1'b1});
    wr(3'd5, 8'h01);
    pulse(0);
    check("R10 flag set by match", irqFlag, 1);
    wr(3'd5, 8'h00);
    check("R10 write 0 keeps flag", irqFlag, 1);
    wr(3'd5, 8'h01);
    check("R10 write 1 clears flag", irqFlag, 0);

    // R9 capture timing and edge-only behaviour
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    wr(3'd0, {2'b00, 3'd0, 2'd1, 1'b1});
    for (int k = 0; k < 7; k++) pulse(0);
    capPin = 1'b1;
    waitN(2);
    check("R9 not yet captured", bVal, 0);
    waitN(1);
    check("R9 captured count", bVal, 7);
    check("R10 flag on capture", irqFlag, 1);
    for (int k = 0; k < 3; k++) pulse(0);
    check("R9 level holds no capture", bVal, 7);
    capPin = 1'b0; waitN(3);
    capPin = 1'b1; waitN(3);
    check("R9 second edge", bVal, 10);
    capPin = 1'b0; waitN(3);
    wr(3'd0, {2'b00, 3'd0, 2'd1, 1'b0});
    capPin = 1'b1; waitN(4);
    check("R9 disabled no capture", bVal, 10);
    capPin = 1'b0;

    // R8 free-run wrap in capture mode
    wr(3'd0, {2'b00, 3'd0, 2'd1, 1'b1});
    tapStrb[0] = 1'b1;
    waitN(65535);
    tapStrb[0] = 1'b0;
    check("R8 reaches top", cntVal, 16'hFFFF);
    pulse(0);
    check("R8 wraps to zero", cntVal, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule